// File: doc/BRIEF.md
# Work Queue Submission Portal

This block sits behind the portal window of a device's MMIO space and receives 64-byte descriptor writes. The write address selects a 4 KB page. The page number identifies the target work queue and one of four portal kinds. These portal kinds combine a bound (limited or unlimited) with an interrupt-table flavour (MSI-X or IMS). For every write, the block decides whether the descriptor enters the queue. When it does, the block hands the descriptor downstream together with its decoded attributes and the PASID that goes with it.

Each queue runs in one of two modes.

- **Shared mode.** The queue serves many clients, which submit with non-posted writes. Each write is answered with Success or Retry. A limited portal is capped at a configured threshold, while an unlimited portal may fill the queue completely.
- **Dedicated mode.** The queue belongs to a single client, which manages flow control itself. A write that finds the queue full is dropped and reported as a software error.

The block keeps an occupancy count for each queue. The count rises on admission and falls on a dequeue pulse from the downstream scheduler.

Top module: `wq_portal`

## Requirements
- R1: The page number is `wr_addr >> PAGE_BITS`. Its low two bits give the portal kind: 0 is unlimited MSI-X, 1 is limited MSI-X, 2 is unlimited IMS and 3 is limited IMS. So bit 0 means limited and bit 1 means IMS. The next Q_W bits give the queue index. An admitted write shows `enq_valid` one cycle after the write, carrying the queue, `enq_limited`, `enq_ims` and the unchanged descriptor.
- R2: A non-posted write through a limited portal of an enabled shared queue is admitted only while the occupancy is below both the threshold and the size. Otherwise it is refused.
- R3: A non-posted write through an unlimited portal of an enabled shared queue is admitted only while the occupancy is below the size.
- R4: Every non-posted write receives exactly one response, one cycle later. `resp_retry` is 0 (Success) exactly when the descriptor was admitted. Posted writes receive no response.
- R5: An enabled dedicated queue treats all four portal kinds alike and admits a write while the occupancy is below the size. A refused write is dropped, and `err_valid` pulses one cycle later with `err_q` naming the queue.
- R6: A posted write aimed at a shared queue is dropped and reported on `err_valid`.
- R7: When IMS_SUPPORTED is 0, writes to IMS portals (kind 2 or 3) are discarded without an error report and without changing occupancy. If such a write was non-posted, it is answered with Retry.
- R8: `rd_valid` follows `rd_req` by one cycle. `rd_data` then holds the same byte in every lane: 0xFF when READ_ONES is 1, and 0x00 otherwise.
- R9: The PASID is chosen by queue mode.
  - A shared queue forwards `wr_pasid` with `enq_pasid_valid` set.
  - A dedicated queue with its PASID enabled forwards its configured PASID and ignores `wr_pasid`.
  - A dedicated queue without PASID gives `enq_pasid_valid` = 0 and `enq_pasid` = 0.
- R10: A configuration write to a disabled queue loads the enable bit, mode, size (clamped to MAX_DEPTH), threshold, PASID enable and PASID. A configuration write to an enabled queue changes only the enable bit.
- R11: A queue that is disabled, or whose size is 0, admits nothing. Non-posted writes to it get Retry. Writes to it that are refused under R5 or R6 are reported as errors.
- R12: Occupancy rises by one on each admission and falls by one on each dequeue pulse to a non-empty queue. A dequeue pulse to an empty queue is ignored. An admission and a dequeue in the same cycle leave the count exact. Admission decisions use the count from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Descriptor write strobe |
| wr_addr | input | ADDR_W | Byte address within the portal window |
| wr_nonposted | input | 1 | Write expects a response |
| wr_pasid | input | 20 | PASID field carried in the descriptor |
| wr_desc | input | DESC_W | Descriptor payload |
| rd_req | input | 1 | Read of the portal window |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | RD_W | Constant read data |
| cfg_we | input | 1 | Queue configuration write |
| cfg_q | input | Q_W | Queue being configured |
| cfg_enable | input | 1 | Enable bit |
| cfg_shared | input | 1 | 1 selects shared mode, 0 selects dedicated mode |
| cfg_size | input | CNT_W | Queue capacity |
| cfg_thresh | input | CNT_W | Limited-portal threshold |
| cfg_pasid_en | input | 1 | Use the configured PASID in dedicated mode |
| cfg_pasid | input | 20 | Configured PASID |
| deq_valid | input | 1 | Dequeue pulse from downstream |
| deq_q | input | Q_W | Queue being dequeued |
| resp_valid | output | 1 | Response to a non-posted write |
| resp_retry | output | 1 | 1 means Retry, 0 means Success |
| enq_valid | output | 1 | Descriptor admitted |
| enq_q | output | Q_W | Target queue |
| enq_limited | output | 1 | Arrived through a limited portal |
| enq_ims | output | 1 | Arrived through an IMS portal |
| enq_pasid_valid | output | 1 | PASID applies |
| enq_pasid | output | 20 | PASID used for the descriptor |
| enq_desc | output | DESC_W | Descriptor payload |
| err_valid | output | 1 | Software error: write dropped |
| err_q | output | Q_W | Queue of the dropped write |
| occupancy | output | NUM_Q*CNT_W | Per-queue descriptor counts, queue 0 in the low bits |

## Verification
The bench builds two copies of the block with four queues, a depth of six and 64-bit descriptors. The first copy supports IMS and reads back 0xFF. The second copy lacks IMS and reads back 0x00. Both copies see the same stimulus, so every IMS-portal write is checked both as a normal submission and as a silent discard.

The small depth lets the bench sweep every queue and portal kind, in both write types, from empty through completely full. The sweeps run across shared queues with different thresholds and across dedicated queues with and without a PASID. One dedicated queue is configured with a size larger than the depth, which exercises the clamp.

The bench then tries reconfiguration while a queue is enabled and a queue of size zero. It applies simultaneous admit and dequeue at the threshold boundary. A long mixed random phase follows, with the expected values computed arithmetically in the bench.

// File: rtl/wq_portal.sv
module wq_portal #(
  parameter int NUM_Q         = 8,
  parameter int MAX_DEPTH     = 16,
  parameter int ADDR_W        = 24,
  parameter int PAGE_BITS     = 12,
  parameter int DESC_W        = 512,
  parameter int RD_W          = 32,
  parameter bit IMS_SUPPORTED = 1'b1,
  parameter bit READ_ONES     = 1'b1,
  localparam int Q_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic                   wr_nonposted,
  input  logic [19:0]            wr_pasid,
  input  logic [DESC_W-1:0]      wr_desc,
  input  logic                   rd_req,
  output logic                   rd_valid,
  output logic [RD_W-1:0]        rd_data,
  input  logic                   cfg_we,
  input  logic [Q_W-1:0]         cfg_q,
  input  logic                   cfg_enable,
  input  logic                   cfg_shared,
  input  logic [CNT_W-1:0]       cfg_size,
  input  logic [CNT_W-1:0]       cfg_thresh,
  input  logic                   cfg_pasid_en,
  input  logic [19:0]            cfg_pasid,
  input  logic                   deq_valid,
  input  logic [Q_W-1:0]         deq_q,
  output logic                   resp_valid,
  output logic                   resp_retry,
  output logic                   enq_valid,
  output logic [Q_W-1:0]         enq_q,
  output logic                   enq_limited,
  output logic                   enq_ims,
  output logic                   enq_pasid_valid,
  output logic [19:0]            enq_pasid,
  output logic [DESC_W-1:0]      enq_desc,
  output logic                   err_valid,
  output logic [Q_W-1:0]         err_q,
  output logic [NUM_Q*CNT_W-1:0] occupancy
);

  localparam logic [CNT_W-1:0] DEPTH_CAP = CNT_W'(MAX_DEPTH);

  logic [CNT_W-1:0] cnt_r  [NUM_Q];
  logic [CNT_W-1:0] size_r [NUM_Q];
  logic [CNT_W-1:0] thr_r  [NUM_Q];
  logic             en_r   [NUM_Q];
  logic             sh_r   [NUM_Q];
  logic             pe_r   [NUM_Q];
  logic [19:0]      pas_r  [NUM_Q];

  wire [1:0]     kind      = wr_addr[PAGE_BITS +: 2];
  wire [Q_W-1:0] qi        = wr_addr[PAGE_BITS+2 +: Q_W];
  wire           lim       = kind[0];
  wire           ims       = kind[1];
  wire           ims_block = ims && !IMS_SUPPORTED;
  wire           room_full = cnt_r[qi] < size_r[qi];
  wire           room_thr  = cnt_r[qi] < thr_r[qi];

  logic accept;
  always_comb begin
    if (!wr_valid || ims_block || !en_r[qi]) accept = 1'b0;
    else if (sh_r[qi])                       accept = wr_nonposted && room_full && (!lim || room_thr);
    else                                     accept = room_full;
  end

  wire drop_err = wr_valid && !ims_block && !accept && (!sh_r[qi] || !wr_nonposted);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    wire inc = accept && (qi == Q_W'(i));
    wire dec = deq_valid && (deq_q == Q_W'(i)) && (cnt_r[i] != '0);
    wire sel = cfg_we && (cfg_q == Q_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)            cnt_r[i] <= '0;
      else if (inc && !dec)  cnt_r[i] <= cnt_r[i] + 1'b1;
      else if (dec && !inc)  cnt_r[i] <= cnt_r[i] - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r[i]   <= 1'b0;
        sh_r[i]   <= 1'b0;
        pe_r[i]   <= 1'b0;
        size_r[i] <= '0;
        thr_r[i]  <= '0;
        pas_r[i]  <= '0;
      end else if (sel) begin
        en_r[i] <= cfg_enable;
        if (!en_r[i]) begin
          sh_r[i]   <= cfg_shared;
          pe_r[i]   <= cfg_pasid_en;
          size_r[i] <= (cfg_size > DEPTH_CAP) ? DEPTH_CAP : cfg_size;
          thr_r[i]  <= cfg_thresh;
          pas_r[i]  <= cfg_pasid;
        end
      end
    end

    assign occupancy[i*CNT_W +: CNT_W] = cnt_r[i];

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_r[i] <= DEPTH_CAP);
    assert_single_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_r[i] == $past(cnt_r[i])) || (cnt_r[i] == $past(cnt_r[i]) + 1'b1) ||
      (cnt_r[i] + 1'b1 == $past(cnt_r[i])));
    assert_threshold_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      enq_valid && (enq_q == Q_W'(i)) && enq_limited && $past(sh_r[i])
      |-> $past(cnt_r[i]) < $past(thr_r[i]));
    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_r[i]) |-> $stable(sh_r[i]) && $stable(size_r[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid      <= 1'b0;
      resp_retry      <= 1'b0;
      enq_valid       <= 1'b0;
      enq_q           <= '0;
      enq_limited     <= 1'b0;
      enq_ims         <= 1'b0;
      enq_pasid_valid <= 1'b0;
      enq_pasid       <= '0;
      enq_desc        <= '0;
      err_valid       <= 1'b0;
      err_q           <= '0;
      rd_valid        <= 1'b0;
    end else begin
      resp_valid      <= wr_valid && wr_nonposted;
      resp_retry      <= !accept;
      enq_valid       <= accept;
      enq_q           <= qi;
      enq_limited     <= lim;
      enq_ims         <= ims;
      enq_pasid_valid <= sh_r[qi] || pe_r[qi];
      enq_pasid       <= sh_r[qi] ? wr_pasid : (pe_r[qi] ? pas_r[qi] : 20'd0);
      enq_desc        <= wr_desc;
      err_valid       <= drop_err;
      err_q           <= qi;
      rd_valid        <= rd_req;
    end
  end

  assign rd_data = {RD_W{READ_ONES}};

  assert_success_matches_enq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && $past(wr_nonposted) |-> resp_valid && !resp_retry);
  assert_drop_not_enqueued_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !enq_valid && !(resp_valid && !resp_retry));
  assert_ims_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !IMS_SUPPORTED && $past(wr_valid && wr_addr[PAGE_BITS+1]) |-> !enq_valid && !err_valid);

endmodule

// File: tb/tb_wq_portal.sv
module tb_wq_portal;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4, DEP = 6, AW = 20, PB = 12, DW = 64, RW = 32;
  localparam int QW = 2, CW = 3;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic wr_valid = 0, wr_nonposted = 0, rd_req = 0, cfg_we = 0, cfg_enable = 0, cfg_shared = 0;
  logic cfg_pasid_en = 0, deq_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [19:0] wr_pasid = '0, cfg_pasid = '0;
  logic [DW-1:0] wr_desc = '0;
  logic [QW-1:0] cfg_q = '0, deq_q = '0;
  logic [CW-1:0] cfg_size = '0, cfg_thresh = '0;

  wire [1:0] resp_v, resp_r, enq_v, enq_l, enq_i, enq_pv, err_v, rd_v;
  wire [QW-1:0] enq_qo [2];
  wire [QW-1:0] err_qo [2];
  wire [19:0] enq_pa [2];
  wire [DW-1:0] enq_d [2];
  wire [NQ*CW-1:0] occ [2];
  wire [RW-1:0] rd_d [2];

  wq_portal #(.NUM_Q(NQ), .MAX_DEPTH(DEP), .ADDR_W(AW), .PAGE_BITS(PB), .DESC_W(DW), .RD_W(RW),
              .IMS_SUPPORTED(1'b1), .READ_ONES(1'b1)) dut (
    .clk, .rst_n, .wr_valid, .wr_addr, .wr_nonposted, .wr_pasid, .wr_desc,
    .rd_req, .rd_valid(rd_v[0]), .rd_data(rd_d[0]),
    .cfg_we, .cfg_q, .cfg_enable, .cfg_shared, .cfg_size, .cfg_thresh, .cfg_pasid_en, .cfg_pasid,
    .deq_valid, .deq_q, .resp_valid(resp_v[0]), .resp_retry(resp_r[0]),
    .enq_valid(enq_v[0]), .enq_q(enq_qo[0]), .enq_limited(enq_l[0]), .enq_ims(enq_i[0]),
    .enq_pasid_valid(enq_pv[0]), .enq_pasid(enq_pa[0]), .enq_desc(enq_d[0]),
    .err_valid(err_v[0]), .err_q(err_qo[0]), .occupancy(occ[0]));

  wq_portal #(.NUM_Q(NQ), .MAX_DEPTH(DEP), .ADDR_W(AW), .PAGE_BITS(PB), .DESC_W(DW), .RD_W(RW),
              .IMS_SUPPORTED(1'b0), .READ_ONES(1'b0)) dut_nims (
    .clk, .rst_n, .wr_valid, .wr_addr, .wr_nonposted, .wr_pasid, .wr_desc,
    .rd_req, .rd_valid(rd_v[1]), .rd_data(rd_d[1]),
    .cfg_we, .cfg_q, .cfg_enable, .cfg_shared, .cfg_size, .cfg_thresh, .cfg_pasid_en, .cfg_pasid,
    .deq_valid, .deq_q, .resp_valid(resp_v[1]), .resp_retry(resp_r[1]),
    .enq_valid(enq_v[1]), .enq_q(enq_qo[1]), .enq_limited(enq_l[1]), .enq_ims(enq_i[1]),
    .enq_pasid_valid(enq_pv[1]), .enq_pasid(enq_pa[1]), .enq_desc(enq_d[1]),
    .err_valid(err_v[1]), .err_q(err_qo[1]), .occupancy(occ[1]));

  int n_cmp = 0, n_bad = 0, seq = 0;
  bit done = 0;
  string ctx = "";
  int  m_cnt [2][NQ];
  bit  m_en [NQ], m_sh [NQ], m_pe [NQ];
  int  m_size [NQ], m_thr [NQ];
  logic [19:0] m_pas [NQ];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s%s: actual %0h expected %0h", ctx, tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(int q, int kind);
    return AW'((q * 4 + kind) * 4096 + 'h40);
  endfunction

  task automatic cfg(int q, bit en, bit sh, int size, int thr, bit pe, logic [19:0] pas);
    cfg_we = 1; cfg_q = QW'(q); cfg_enable = en; cfg_shared = sh; cfg_size = CW'(size);
    cfg_thresh = CW'(thr); cfg_pasid_en = pe; cfg_pasid = pas;
    @(negedge clk);
    if (!m_en[q]) begin
      m_sh[q] = sh; m_pe[q] = pe; m_size[q] = (size > DEP) ? DEP : size;
      m_thr[q] = thr; m_pas[q] = pas;
    end
    m_en[q] = en;
    cfg_we = 0;
  endtask

  task automatic op(bit w, int q, int kind, bit np, logic [19:0] pas, bit dq_en, int dq);
    bit acc [2];
    bit err [2];
    string tg [2];
    logic [DW-1:0] desc;
    desc = {32'hD5000000 + 32'(seq), ~32'(seq)};
    seq++;
    for (int d = 0; d < 2; d++) begin
      acc[d] = 0; err[d] = 0; tg[d] = "R4";
      if (w) begin
        if (d == 1 && kind >= 2) tg[d] = "R7";
        else begin
          if (!m_en[q] || m_size[q] == 0) tg[d] = "R11";
          else if (!m_sh[q]) tg[d] = "R5";
          else if (!np) tg[d] = "R6";
          else if (kind % 2 == 1) tg[d] = "R2";
          else tg[d] = "R3";
          if (m_en[q]) begin
            if (m_sh[q]) acc[d] = np && (m_cnt[d][q] < m_size[q]) && (kind % 2 == 0 || m_cnt[d][q] < m_thr[q]);
            else acc[d] = m_cnt[d][q] < m_size[q];
          end
          err[d] = !acc[d] && (!m_sh[q] || !np);
        end
      end
    end
    wr_valid = w; wr_addr = mk_addr(q, kind); wr_nonposted = np; wr_pasid = pas; wr_desc = desc;
    deq_valid = dq_en; deq_q = QW'(dq);
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk({tg[d], " R4 resp_valid"}, 64'(resp_v[d]), 64'(w && np));
      if (w && np) chk({tg[d], " resp_retry"}, 64'(resp_r[d]), 64'(!acc[d]));
      chk({tg[d], " enq_valid"}, 64'(enq_v[d]), 64'(acc[d]));
      chk({tg[d], " err_valid"}, 64'(err_v[d]), 64'(err[d]));
      if (acc[d]) begin
        chk("R1 enq_q", 64'(enq_qo[d]), 64'(q));
        chk("R1 enq_limited", 64'(enq_l[d]), 64'(kind % 2));
        chk("R1 enq_ims", 64'(enq_i[d]), 64'(kind / 2));
        chk("R1 enq_desc", 64'(enq_d[d]), 64'(desc));
        chk("R9 pasid_valid", 64'(enq_pv[d]), 64'(m_sh[q] || m_pe[q]));
        chk("R9 pasid", 64'(enq_pa[d]), 64'(m_sh[q] ? pas : (m_pe[q] ? m_pas[q] : 20'd0)));
      end
      if (err[d]) chk("R5 err_q", 64'(err_qo[d]), 64'(q));
      if (dq_en && m_cnt[d][dq] > 0) m_cnt[d][dq]--;
      if (acc[d]) m_cnt[d][q]++;
      for (int k = 0; k < NQ; k++)
        chk("R12 occupancy", 64'(occ[d][k*CW +: CW]), 64'(m_cnt[d][k]));
    end
    wr_valid = 0; deq_valid = 0;
  endtask

  task automatic drain(int q);
    for (int i = 0; i < DEP + 1; i++) op(0, 0, 0, 0, 0, 1, q);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) for (int k = 0; k < NQ; k++) m_cnt[d][k] = 0;
    for (int k = 0; k < NQ; k++) begin
      m_en[k] = 0; m_sh[k] = 0; m_pe[k] = 0; m_size[k] = 0; m_thr[k] = 0; m_pas[k] = 0;
    end
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R4 reset resp", 64'(resp_v[d]), 0);
      chk("R1 reset enq", 64'(enq_v[d]), 0);
      chk("R5 reset err", 64'(err_v[d]), 0);
      chk("R12 reset occupancy", 64'(occ[d]), 0);
    end
    rst_n = 1;
    @(negedge clk);

    cfg(0, 1, 1, 6, 3, 0, 20'h0);
    cfg(1, 1, 1, 4, 1, 0, 20'h0);
    cfg(2, 1, 0, 3, 0, 1, 20'hABCDE);
    cfg(3, 1, 0, 7, 0, 0, 20'h12345);

    for (int q = 0; q < NQ; q++)
      for (int kind = 0; kind < 4; kind++)
        for (int np = 0; np < 2; np++) begin
          for (int i = 0; i < DEP + 1; i++) op(1, q, kind, np[0], 20'(20'h5A000 + i), 0, 0);
          drain(q);
        end

    for (int i = 0; i < 3; i++) op(1, 0, 0, 1, 20'h1, 0, 0);
    op(1, 0, 1, 1, 20'h2, 1, 0);
    op(1, 0, 1, 1, 20'h3, 1, 0);
    op(1, 0, 1, 1, 20'h4, 1, 0);
    for (int i = 0; i < 4; i++) op(1, 0, 0, 1, 20'h5, 1, 0);
    drain(0);
    op(0, 0, 0, 0, 0, 1, 1);

    ctx = "R10 ";
    cfg(0, 1, 0, 2, 0, 1, 20'h77777);
    for (int i = 0; i < 7; i++) op(1, 0, 1, 1, 20'h9, 0, 0);
    drain(0);
    cfg(0, 0, 0, 2, 0, 1, 20'h77777);
    ctx = "R11 ";
    op(1, 0, 0, 1, 20'h9, 0, 0);
    op(1, 0, 0, 0, 20'h9, 0, 0);
    ctx = "R10 ";
    cfg(0, 1, 0, 2, 0, 1, 20'h77777);
    for (int i = 0; i < 3; i++) op(1, 0, 3, 0, 20'h9, 0, 0);
    drain(0);
    ctx = "R11 ";
    cfg(1, 0, 1, 4, 1, 0, 0);
    cfg(1, 1, 1, 0, 0, 0, 0);
    op(1, 1, 0, 1, 20'h8, 0, 0);
    op(1, 1, 1, 1, 20'h8, 0, 0);
    cfg(1, 0, 1, 0, 0, 0, 0);
    cfg(1, 1, 1, 5, 2, 0, 0);
    ctx = "";

    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    chk("R8 rd_valid", 64'(rd_v[0]), 1);
    chk("R8 rd_data ones", 64'(rd_d[0]), 64'hFFFFFFFF);
    chk("R8 rd_valid", 64'(rd_v[1]), 1);
    chk("R8 rd_data zeros", 64'(rd_d[1]), 0);
    @(negedge clk);
    chk("R8 rd_valid low", 64'(rd_v[0]), 0);

    for (int i = 0; i < 3000; i++)
      op($urandom_range(0, 3) != 0, $urandom_range(0, NQ - 1), $urandom_range(0, 3),
         $urandom_range(0, 3) != 0, 20'($urandom), $urandom_range(0, 2) == 0, $urandom_range(0, NQ - 1));

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule